// File: doc/BRIEF.md
# Sobel Edge Detector with Direct Window Addressing

The block turns an 8-bit grayscale image held in an external row-major pixel memory into a stream of one-bit edge decisions. It keeps no line buffers and no copy of the 3x3 neighbourhood. For every interior output position it works out the nine neighbour addresses from the centre address and the image width. It then reads them one at a time through a synchronous read port and accumulates a horizontal and a vertical gradient on the fly.

A start pulse latches the image width and height and begins a raster scan, left to right within a row and rows top to bottom. Every pixel position yields exactly one qualified output bit. Border positions are answered at once with 0 and cause no memory traffic. Interior positions take nine reads plus a short drain. A one-cycle done pulse follows the last output, and the block is then ready for the next image.

Top module: `sobel_idx_edge`

## Requirements
- R1: After reset, edge_valid_o, done_o, busy_o and mem_rd_o are all 0.
- R2: start_i is accepted only while busy_o is 0, and width_i and height_i are latched at acceptance. A start_i seen while busy_o is 1 has no effect on the frame in progress and does not begin a further frame.
- R3: An accepted frame of W columns and H rows (both at least 1) produces exactly W*H cycles with edge_valid_o high, in raster order: column index rising within a row, then the next row.
- R4: A pixel in row 0, row H-1, column 0 or column W-1 outputs edge_bit_o = 0 and causes no memory read. When W or H is below 3, every pixel is a border pixel.
- R5: For an interior pixel at centre address a = r*W + c, exactly nine reads are issued, one per cycle, at a-W-1, a-W, a-W+1, a-1, a, a+1, a+W-1, a+W, a+W+1 in that order. mem_data_i is taken one cycle after each read.
- R6: The horizontal gradient uses the mask [-1 0 1; -2 0 2; -1 0 1] over the window rows top to bottom. The vertical gradient uses its transpose [-1 -2 -1; 0 0 0; 1 2 1].
- R7: The magnitude is (|Gx| >> 2) + (|Gy| >> 2), saturated at 255.
- R8: edge_bit_o is 1 only when the magnitude is strictly greater than 27. A magnitude of exactly 27 gives 0.
- R9: done_o is high for exactly one cycle, the cycle right after the last edge_valid_o of the frame, and busy_o is 0 in that cycle. A start_i in that same cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a frame when idle |
| width_i | input | DIM_W | Image width in pixels, latched at start |
| height_i | input | DIM_W | Image height in pixels, latched at start |
| mem_addr_o | output | ADDR_W | Pixel memory read address |
| mem_rd_o | output | 1 | Pixel memory read strobe |
| mem_data_i | input | PIX_W | Read data, valid one cycle after mem_rd_o |
| edge_valid_o | output | 1 | Qualifies edge_bit_o, one cycle per pixel |
| edge_bit_o | output | 1 | Edge decision for the current pixel |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse after the last output |

## Verification
Two events can meet in one cycle: the end-of-frame done pulse and a fresh start request. The bench holds start_i high for two cycles. The first cycle coincides with the last output, while the controller is still busy, so that request must be ignored. The second coincides with done_o, when the block is idle, so that request must launch exactly one new frame. The bench then requires a full second frame with the correct pixel count and addresses, a second done pulse, and no third frame. Threshold edges are probed with step images whose magnitude lands on 27 and on 28.

// File: rtl/sobel_idx_pkg.sv
package sobel_idx_pkg;
  localparam int TAPS  = 9;
  localparam int TAP_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PIX, ST_READ, ST_DRAIN, ST_FIN, ST_DONE
  } scan_state_e;

  // tap k scans the window row-major: dy = k/3 - 1, dx = k%3 - 1
  function automatic int tap_wx(input int k);
    int dx, dy;
    dx = (k % 3) - 1;
    dy = (k / 3) - 1;
    return dx * ((dy == 0) ? 2 : 1);
  endfunction

  function automatic int tap_wy(input int k);
    int dx, dy;
    dx = (k % 3) - 1;
    dy = (k / 3) - 1;
    return dy * ((dx == 0) ? 2 : 1);
  endfunction
endpackage

// File: rtl/sobel_win_addr.sv
module sobel_win_addr
  import sobel_idx_pkg::*;
#(
  parameter int DIM_W  = 8,
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] centre_i,
  input  logic [DIM_W-1:0]  width_i,
  input  logic [TAP_W-1:0]  tap_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] w_ext;
  logic [ADDR_W-1:0] row_base;

  assign w_ext = ADDR_W'(width_i);

  always_comb begin
    if (tap_i < TAP_W'(3))      row_base = centre_i - w_ext;
    else if (tap_i < TAP_W'(6)) row_base = centre_i;
    else                        row_base = centre_i + w_ext;
    case (tap_i)
      TAP_W'(0), TAP_W'(3), TAP_W'(6): addr_o = row_base - 1'b1;
      TAP_W'(2), TAP_W'(5), TAP_W'(8): addr_o = row_base + 1'b1;
      default:                         addr_o = row_base;
    endcase
  end
endmodule

// File: rtl/sobel_grad_acc.sv
module sobel_grad_acc
  import sobel_idx_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int THRESH = 27
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             rd_i,
  input  logic [TAP_W-1:0] tap_i,
  input  logic [PIX_W-1:0] pix_i,
  output logic             edge_o
);
  localparam int ACC_W = PIX_W + 4;
  localparam logic [ACC_W-1:0] MAG_MAX = ACC_W'((1 << PIX_W) - 1);

  logic signed [ACC_W-1:0] wx_tab [TAPS];
  logic signed [ACC_W-1:0] wy_tab [TAPS];

  for (genvar k = 0; k < TAPS; k++) begin : g_wt
    assign wx_tab[k] = ACC_W'(tap_wx(k));
    assign wy_tab[k] = ACC_W'(tap_wy(k));
  end

  logic                    rd_q;
  logic [TAP_W-1:0]        tap_q;
  logic signed [ACC_W-1:0] gx_q, gy_q;
  logic signed [ACC_W-1:0] pix_s;

  assign pix_s = $signed({{(ACC_W-PIX_W){1'b0}}, pix_i});

  // data returns one cycle after the read strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= 1'b0;
      tap_q <= '0;
      gx_q  <= '0;
      gy_q  <= '0;
    end else begin
      rd_q  <= rd_i;
      tap_q <= tap_i;
      if (clr_i) begin
        gx_q <= '0;
        gy_q <= '0;
      end else if (rd_q) begin
        gx_q <= gx_q + wx_tab[tap_q] * pix_s;
        gy_q <= gy_q + wy_tab[tap_q] * pix_s;
      end
    end
  end

  logic [ACC_W-1:0] ax, ay, msum;
  logic [PIX_W-1:0] mag;

  always_comb begin
    ax   = gx_q[ACC_W-1] ? ACC_W'(-gx_q) : ACC_W'(gx_q);
    ay   = gy_q[ACC_W-1] ? ACC_W'(-gy_q) : ACC_W'(gy_q);
    msum = (ax >> 2) + (ay >> 2);
    mag  = (msum > MAG_MAX) ? MAG_MAX[PIX_W-1:0] : msum[PIX_W-1:0];
  end

  assign edge_o = mag > PIX_W'(THRESH);
endmodule

// File: rtl/sobel_scan_ctrl.sv
module sobel_scan_ctrl
  import sobel_idx_pkg::*;
#(
  parameter int DIM_W  = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DIM_W-1:0]  width_i,
  input  logic [DIM_W-1:0]  height_i,
  input  logic              edge_i,
  output logic [TAP_W-1:0]  tap_o,
  output logic              rd_o,
  output logic              clr_o,
  output logic [ADDR_W-1:0] centre_o,
  output logic [DIM_W-1:0]  width_o,
  output logic              valid_o,
  output logic              bit_o,
  output logic              busy_o,
  output logic              done_o
);
  scan_state_e       state_q;
  logic [DIM_W-1:0]  w_q, h_q, row_q, col_q;
  logic [ADDR_W-1:0] centre_q;
  logic [TAP_W-1:0]  tap_q;
  logic              valid_q, bit_q, done_q;
  logic              interior, last_pix, adv;

  assign interior = (row_q != '0) && (col_q != '0) &&
                    (row_q != h_q - 1'b1) && (col_q != w_q - 1'b1);
  assign last_pix = (row_q == h_q - 1'b1) && (col_q == w_q - 1'b1);
  assign adv      = (state_q == ST_PIX && !interior) || (state_q == ST_FIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      w_q     <= '0;
      h_q     <= '0;
      tap_q   <= '0;
      valid_q <= 1'b0;
      bit_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          w_q     <= width_i;
          h_q     <= height_i;
          state_q <= ST_PIX;
        end
        ST_PIX: if (interior) begin
          tap_q   <= '0;
          state_q <= ST_READ;
        end
        ST_READ: begin
          if (tap_q == TAP_W'(TAPS - 1)) state_q <= ST_DRAIN;
          else                           tap_q   <= tap_q + 1'b1;
        end
        ST_DRAIN: state_q <= ST_FIN;
        ST_DONE: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: ;
      endcase
      if (adv) begin
        valid_q <= 1'b1;
        bit_q   <= (state_q == ST_FIN) ? edge_i : 1'b0;
        state_q <= last_pix ? ST_DONE : ST_PIX;
      end
    end
  end

  // raster position and centre address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q    <= '0;
      col_q    <= '0;
      centre_q <= '0;
    end else if (state_q == ST_IDLE) begin
      row_q    <= '0;
      col_q    <= '0;
      centre_q <= '0;
    end else if (adv && !last_pix) begin
      centre_q <= centre_q + 1'b1;
      if (col_q == w_q - 1'b1) begin
        col_q <= '0;
        row_q <= row_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  assign tap_o    = tap_q;
  assign rd_o     = (state_q == ST_READ);
  assign clr_o    = (state_q == ST_PIX) && interior;
  assign centre_o = centre_q;
  assign width_o  = w_q;
  assign valid_o  = valid_q;
  assign bit_o    = bit_q;
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
endmodule

// File: rtl/sobel_idx_edge.sv
module sobel_idx_edge
  import sobel_idx_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int DIM_W  = 8,
  parameter int ADDR_W = 16,
  parameter int THRESH = 27
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DIM_W-1:0]  width_i,
  input  logic [DIM_W-1:0]  height_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  input  logic [PIX_W-1:0]  mem_data_i,
  output logic              edge_valid_o,
  output logic              edge_bit_o,
  output logic              busy_o,
  output logic              done_o
);
  logic [TAP_W-1:0]  tap;
  logic              rd, clr, edge_raw;
  logic [ADDR_W-1:0] centre;
  logic [DIM_W-1:0]  width_q;

  sobel_scan_ctrl #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .width_i  (width_i),
    .height_i (height_i),
    .edge_i   (edge_raw),
    .tap_o    (tap),
    .rd_o     (rd),
    .clr_o    (clr),
    .centre_o (centre),
    .width_o  (width_q),
    .valid_o  (edge_valid_o),
    .bit_o    (edge_bit_o),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  sobel_win_addr #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_addr (
    .centre_i (centre),
    .width_i  (width_q),
    .tap_i    (tap),
    .addr_o   (mem_addr_o)
  );

  sobel_grad_acc #(.PIX_W(PIX_W), .THRESH(THRESH)) u_grad (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .rd_i   (rd),
    .tap_i  (tap),
    .pix_i  (mem_data_i),
    .edge_o (edge_raw)
  );

  assign mem_rd_o = rd;
endmodule

// File: rtl/sobel_idx_edge_chk.sv
module sobel_idx_edge_chk #(
  parameter int DIM_W  = 8,
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [DIM_W-1:0]  width_i,
  input logic [DIM_W-1:0]  height_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_rd_o,
  input logic              edge_valid_o,
  input logic              busy_o,
  input logic              done_o
);
  localparam int CNT_W = 2 * DIM_W + 1;

  logic [DIM_W-1:0] fw, fh;
  logic [CNT_W-1:0] out_cnt, frame_px;
  logic [3:0]       rd_since;

  assign frame_px = CNT_W'(fw) * CNT_W'(fh);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fw       <= '0;
      fh       <= '0;
      out_cnt  <= '0;
      rd_since <= '0;
    end else begin
      if (start_i && !busy_o) begin
        fw      <= width_i;
        fh      <= height_i;
        out_cnt <= '0;
      end else if (edge_valid_o) begin
        out_cnt <= out_cnt + 1'b1;
      end
      if (edge_valid_o)  rd_since <= '0;
      else if (mem_rd_o) rd_since <= rd_since + 1'b1;
    end
  end

  AST_IDLE_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_rd_o); // R5
  AST_ADDR_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> (CNT_W'(mem_addr_o) < frame_px)); // R5
  AST_READS_PER_PIXEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_valid_o |-> (rd_since == 4'd0 || rd_since == 4'd9)); // R4
  AST_FRAME_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (out_cnt == frame_px)); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R9
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(edge_valid_o)); // R9
endmodule

bind sobel_idx_edge sobel_idx_edge_chk #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .width_i      (width_i),
  .height_i     (height_i),
  .mem_addr_o   (mem_addr_o),
  .mem_rd_o     (mem_rd_o),
  .edge_valid_o (edge_valid_o),
  .busy_o       (busy_o),
  .done_o       (done_o)
);

// File: tb/sobel_idx_edge_tb.sv
module sobel_idx_edge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  width_i = '0, height_i = '0;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_data = '0;
  logic        edge_valid, edge_bit, busy, done;

  always #10 clk = ~clk;

  sobel_idx_edge u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .width_i(width_i),
    .height_i(height_i), .mem_addr_o(mem_addr), .mem_rd_o(mem_rd),
    .mem_data_i(mem_data), .edge_valid_o(edge_valid), .edge_bit_o(edge_bit),
    .busy_o(busy), .done_o(done)
  );

  logic [7:0] mem [0:1023];
  always @(posedge clk) if (mem_rd) mem_data <= mem[mem_addr[9:0]];

  int n_tests = 0, n_fail = 0, cyc = 0;
  int fw = 1, fh = 1;
  int out_cnt, oc_r, oc_c, ir, ic, tap, rd_total, rd_since, done_cnt;
  bit prev_valid = 0;
  int unsigned seed = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int px(input int r, input int c);
    return int'(mem[r * fw + c]);
  endfunction

  function automatic bit exp_bit(input int r, input int c);
    int gx, gy, mag;
    if (r == 0 || c == 0 || r == fh - 1 || c == fw - 1) return 1'b0;
    gx = px(r-1,c+1) + 2*px(r,c+1) + px(r+1,c+1) - px(r-1,c-1) - 2*px(r,c-1) - px(r+1,c-1);
    gy = px(r+1,c-1) + 2*px(r+1,c) + px(r+1,c+1) - px(r-1,c-1) - 2*px(r-1,c) - px(r-1,c+1);
    if (gx < 0) gx = -gx;
    if (gy < 0) gy = -gy;
    mag = (gx >> 2) + (gy >> 2);
    if (mag > 255) mag = 255;
    return mag > 27;
  endfunction

  task automatic reset_track();
    out_cnt = 0; oc_r = 0; oc_c = 0; ir = 1; ic = 1; tap = 0;
    rd_total = 0; rd_since = 0;
  endtask

  // output and read monitor
  always @(negedge clk) if (rst_n) begin
    if (mem_rd) begin
      int ea;
      ea = (ir + tap / 3 - 1) * fw + (ic + tap % 3 - 1);
      chk(int'(mem_addr) == ea, "R5 addr", int'(mem_addr), ea);
      rd_total++; rd_since++; tap++;
      if (tap == 9) begin
        tap = 0; ic++;
        if (ic > fw - 2) begin ic = 1; ir++; end
      end
    end
    if (edge_valid) begin
      bit eb;
      bit border;
      border = (oc_r == 0 || oc_c == 0 || oc_r == fh - 1 || oc_c == fw - 1);
      eb = exp_bit(oc_r, oc_c);
      if (border) begin
        chk(edge_bit == 1'b0, "R4 border bit", edge_bit, 0);
        chk(rd_since == 0, "R4 border reads", rd_since, 0);
      end else begin
        chk(edge_bit == eb, "R6/R7/R8 edge bit", edge_bit, eb);
        chk(rd_since == 9, "R5 reads per pixel", rd_since, 9);
      end
      rd_since = 0; out_cnt++; oc_c++;
      if (oc_c == fw) begin oc_c = 0; oc_r++; end
    end
    if (done) begin
      done_cnt++;
      chk(out_cnt == fw * fh, "R3 output count", out_cnt, fw * fh);
      chk(prev_valid, "R9 done after last", prev_valid, 1);
      chk(!busy, "R9 idle at done", busy, 0);
    end
    prev_valid = edge_valid;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic logic [7:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[23:16];
  endfunction

  // 0: step of 27, 1: step of 28, 2: random, 3: dark quadrant, 4: flat 255
  task automatic fill(input int kind, input int w, input int h);
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++) begin
        logic [7:0] v;
        case (kind)
          0: v = (c >= 4) ? 8'd67 : 8'd40;
          1: v = (c >= 4) ? 8'd68 : 8'd40;
          2: v = rnd();
          3: v = (r < h / 2 && c < w / 2) ? 8'd0 : 8'd255;
          default: v = 8'd255;
        endcase
        mem[r * w + c] = v;
      end
  endtask

  task automatic wait_done(input int d0);
    for (int i = 0; i < 20000 && done_cnt == d0; i++) @(negedge clk);
    chk(done_cnt == d0 + 1, "R9 frame completes", done_cnt, d0 + 1);
  endtask

  task automatic run_frame(input int w, input int h, input int kind, input bit poke);
    int d0;
    fill(kind, w, h);
    @(negedge clk);
    fw = w; fh = h; reset_track(); d0 = done_cnt;
    width_i = 8'(w); height_i = 8'(h); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      width_i = 8'd3; height_i = 8'd3; start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      repeat (30) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
    end
    wait_done(d0);
    chk(out_cnt == w * h, poke ? "R2 busy start ignored" : "R3 frame count", out_cnt, w * h);
    chk(rd_total == ((w >= 3 && h >= 3) ? (w - 2) * (h - 2) * 9 : 0),
        "R4 read total", rd_total, (w >= 3 && h >= 3) ? (w - 2) * (h - 2) * 9 : 0);
    if (poke) begin
      repeat (40) @(negedge clk);
      chk(!busy && done_cnt == d0 + 1, "R2 no extra frame", done_cnt, d0 + 1);
    end
  endtask

  // start held across the last output cycle and the done cycle
  task automatic overlap_test();
    int d0;
    fill(2, 6, 4);
    @(negedge clk);
    fw = 6; fh = 4; reset_track(); d0 = done_cnt;
    width_i = 8'd6; height_i = 8'd4; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    for (int i = 0; i < 20000 && out_cnt < 24; i++) begin @(negedge clk); #1; end
    start_i = 1'b1;
    @(negedge clk); #1;
    chk(done == 1'b1, "R9 done cycle", done, 1);
    chk(busy == 1'b0, "R9 idle in done cycle", busy, 0);
    reset_track();
    @(negedge clk); #1;
    start_i = 1'b0;
    chk(busy == 1'b1, "R9 start in done cycle accepted", busy, 1);
    wait_done(d0 + 1);
    chk(out_cnt == 24, "R2 single relaunch", out_cnt, 24);
    repeat (30) @(negedge clk);
    chk(done_cnt == d0 + 2 && !busy, "R2 no third frame", done_cnt, d0 + 2);
  endtask

  initial begin
    done_cnt = 0;
    reset_track();
    repeat (3) @(negedge clk);
    chk(!edge_valid && !done && !busy && !mem_rd, "R1 reset outputs",
        {edge_valid, done, busy, mem_rd}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!edge_valid && !done && !busy && !mem_rd, "R1 idle after reset",
        {edge_valid, done, busy, mem_rd}, 0);
    run_frame(8, 6, 0, 1'b0);   // R8: magnitude exactly 27
    run_frame(8, 6, 1, 1'b0);   // R8: magnitude 28
    run_frame(7, 5, 2, 1'b0);
    run_frame(6, 6, 3, 1'b0);   // R7: saturation at the dark corner
    run_frame(5, 4, 4, 1'b0);   // R6: flat image, zero gradient
    run_frame(3, 3, 2, 1'b0);
    run_frame(2, 5, 2, 1'b0);   // R4: too narrow for any interior
    run_frame(1, 1, 2, 1'b0);
    run_frame(16, 4, 2, 1'b1);  // R2: starts while busy
    overlap_test();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule